// File: doc/BRIEF.md
# Compacting VLIW Issue-Slot Dispatcher

The dispatcher accepts a fetch group of four 32-bit operation words. It finds where the current instruction bundle ends and sends each operation in that bundle to an issue port that can run its class. The bundle ends at the first word whose top bit is set, so a bundle holds between one and four operations. Words after that one are ignored.

There are six issue ports: two integer ports, two float/media ports and two branch ports. An operation is not tied to a fixed position in the word. Operations of one class take that class's ports in program order, lower port first, so no port is filled with a NOP. Each port output carries the routed word, a valid flag and the lane index the word came from in the fetch group.

The bundle is rejected, and an error flag is raised instead, in three cases: a class asks for more than two ports, a reserved class code appears, or none of the four words ends the bundle. When a bundle is rejected, no port issues. All results are registered, so a bundle presented in one cycle appears at the ports after the next rising clock edge.

Top module: `vliw_issue_dispatch`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, every `port_valid` bit, `bundle_err`, every `port_op` field and every `port_pos` field are zero.
- R2: The bundle covers lanes 0 up to and including the lowest lane whose bit 31 is 1. Lanes above that lane have no effect on any output.
- R3: The class of an operation is taken from bits 30:29: 2'b00 integer, 2'b01 float/media, 2'b10 branch, 2'b11 reserved.
- R4: Port indices are fixed: 0 = integer-A, 1 = float/media-A, 2 = integer-B, 3 = float/media-B, 4 = branch-A, 5 = branch-B. The first operation of a class in lane order goes to that class's A port and the second goes to its B port. A B port is never valid while its A port is idle.
- R5: `port_pos` of a valid port holds the 2-bit lane index (0 to 3) of the routed operation. `port_op` holds the full 32-bit word unchanged.
- R6: If a bundle holds three or more operations of one class, `bundle_err` is 1 and no port is valid.
- R7: If a bundle contains an operation of the reserved class, `bundle_err` is 1 and no port is valid.
- R8: If none of the four lanes has bit 31 set, `bundle_err` is 1 and no port is valid.
- R9: While `bundle_valid` is 0, the next outputs show no valid port and `bundle_err` is 0, whatever is on `bundle_ops`.
- R10: Outputs change only at a rising clock edge. A bundle presented before an edge appears on the ports after that edge, and not before it.
- R11: A port that is not valid drives zero on its `port_op` and `port_pos` fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bundle_valid | input | 1 | A fetch group is presented this cycle |
| bundle_ops | input | 128 | Four operation words; lane i occupies bits 32*i+31 : 32*i |
| port_valid | output | 6 | Per-port issue flag, bit p for port p |
| port_op | output | 192 | Per-port operation word; port p occupies bits 32*p+31 : 32*p |
| port_pos | output | 12 | Per-port source lane; port p occupies bits 2*p+1 : 2*p |
| bundle_err | output | 1 | The registered bundle was rejected |

## Verification
The assertions assume that `bundle_valid` and `bundle_ops` are driven to known values in every cycle outside reset. They also assume that every valid group is presented as a complete 128-bit word within a single cycle. The bench meets both assumptions by changing its inputs only on the falling edge and by never leaving a lane undriven. It sweeps every combination of the four lane class codes with every pattern of the four end bits, 4096 groups in all. Each word carries a unique payload, so a misrouted operation cannot pass unnoticed. Idle cycles also carry non-zero words on `bundle_ops`, so that R9 is exercised.

// File: rtl/vliw_disp_pkg.sv
package vliw_disp_pkg;

    localparam int OP_W      = 32;
    localparam int NUM_LANES = 4;
    localparam int NUM_PORTS = 6;
    localparam int PER_CLASS = 2;
    localparam int POS_W     = $clog2(NUM_LANES);
    localparam int END_BIT   = OP_W - 1;
    localparam int CLS_HI    = OP_W - 2;
    localparam int CLS_LO    = OP_W - 3;
    localparam int NUM_CLS   = 3;
    localparam int BR_BASE   = 2 * PER_CLASS;

    typedef enum logic [1:0] {
        CLS_INT = 2'b00,
        CLS_FM  = 2'b01,
        CLS_BR  = 2'b10,
        CLS_RSV = 2'b11
    } op_class_e;

    typedef struct packed {
        logic             vld;
        logic [POS_W-1:0] pos;
        logic [OP_W-1:0]  op;
    } port_slot_t;

    typedef logic [NUM_LANES-1:0][OP_W-1:0] lane_vec_t;
    typedef port_slot_t [NUM_PORTS-1:0]     slot_vec_t;

    function automatic op_class_e class_of(input logic [OP_W-1:0] w);
        return op_class_e'(w[CLS_HI:CLS_LO]);
    endfunction

    // Integer and float/media ports interleave; branch ports sit at the top.
    function automatic int port_of(input op_class_e c, input int rank);
        if (c == CLS_BR)
            return BR_BASE + rank;
        return rank * 2 + int'(c);
    endfunction

endpackage

// File: rtl/vliw_len_dec.sv
module vliw_len_dec
    import vliw_disp_pkg::*;
(
    input  logic [NUM_LANES-1:0] end_bits,
    output logic [NUM_LANES-1:0] lane_used,
    output logic                 no_end
);
    logic seen;

    always_comb begin
        seen = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            lane_used[i] = !seen;
            if (end_bits[i])
                seen = 1'b1;
        end
        no_end = !seen;
    end

endmodule

// File: rtl/vliw_slot_route.sv
module vliw_slot_route
    import vliw_disp_pkg::*;
(
    input  lane_vec_t            lanes,
    input  logic [NUM_LANES-1:0] lane_used,
    output slot_vec_t            slots,
    output logic                 overflow,
    output logic                 rsv_seen
);
    int        cnt [NUM_CLS];
    int        rank;
    op_class_e cls;

    always_comb begin
        slots    = '0;
        overflow = 1'b0;
        rsv_seen = 1'b0;
        rank     = 0;
        cls      = CLS_INT;
        for (int k = 0; k < NUM_CLS; k++)
            cnt[k] = 0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (lane_used[i]) begin
                cls = class_of(lanes[i]);
                if (cls == CLS_RSV) begin
                    rsv_seen = 1'b1;
                end else begin
                    rank = cnt[int'(cls)];
                    cnt[int'(cls)] = rank + 1;
                    if (rank < PER_CLASS) begin
                        slots[port_of(cls, rank)].vld = 1'b1;
                        slots[port_of(cls, rank)].pos = POS_W'(i);
                        slots[port_of(cls, rank)].op  = lanes[i];
                    end else begin
                        overflow = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/vliw_issue_dispatch.sv
module vliw_issue_dispatch
    import vliw_disp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bundle_valid,
    input  logic [NUM_LANES*OP_W-1:0]   bundle_ops,
    output logic [NUM_PORTS-1:0]        port_valid,
    output logic [NUM_PORTS*OP_W-1:0]   port_op,
    output logic [NUM_PORTS*POS_W-1:0]  port_pos,
    output logic                        bundle_err
);
    lane_vec_t            lanes;
    logic [NUM_LANES-1:0] end_bits;
    logic [NUM_LANES-1:0] lane_used;
    logic                 no_end;
    slot_vec_t            slots_d, slots_q;
    logic                 overflow, rsv_seen, fault;
    logic                 err_q;

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            assign lanes[i]    = bundle_ops[i*OP_W +: OP_W];
            assign end_bits[i] = lanes[i][END_BIT];
        end
    endgenerate

    vliw_len_dec u_len (
        .end_bits  (end_bits),
        .lane_used (lane_used),
        .no_end    (no_end)
    );

    vliw_slot_route u_route (
        .lanes     (lanes),
        .lane_used (lane_used),
        .slots     (slots_d),
        .overflow  (overflow),
        .rsv_seen  (rsv_seen)
    );

    assign fault = no_end | overflow | rsv_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
            err_q   <= 1'b0;
        end else if (!bundle_valid) begin
            slots_q <= '0;
            err_q   <= 1'b0;
        end else if (fault) begin
            slots_q <= '0;
            err_q   <= 1'b1;
        end else begin
            slots_q <= slots_d;
            err_q   <= 1'b0;
        end
    end

    assign bundle_err = err_q;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            assign port_valid[p]                = slots_q[p].vld;
            assign port_op[p*OP_W +: OP_W]      = slots_q[p].op;
            assign port_pos[p*POS_W +: POS_W]   = slots_q[p].pos;

            // R11
            idle_port_zero_chk: assert property (@(posedge clk) disable iff (rst)
                !port_valid[p] |-> (port_op[p*OP_W +: OP_W] == '0 &&
                                    port_pos[p*POS_W +: POS_W] == '0));
        end
    endgenerate

    // R9
    idle_cycle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bundle_valid |=> (port_valid == '0 && !bundle_err));

    // R6
    rejected_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (bundle_valid && overflow) |=> (bundle_err && port_valid == '0));

    // R8
    missing_end_chk: assert property (@(posedge clk) disable iff (rst)
        (bundle_valid && no_end) |=> bundle_err);

    // R4
    int_order_chk: assert property (@(posedge clk) disable iff (rst)
        port_valid[2] |-> port_valid[0]);

    // R4
    fm_order_chk: assert property (@(posedge clk) disable iff (rst)
        port_valid[3] |-> port_valid[1]);

    // R4
    br_order_chk: assert property (@(posedge clk) disable iff (rst)
        port_valid[5] |-> port_valid[4]);

    // R2
    issue_width_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(port_valid) <= NUM_LANES);

endmodule

// File: tb/tb_vliw_issue_dispatch.sv
`timescale 1ns/1ps
module tb_vliw_issue_dispatch;

    logic         clk = 1'b0;
    logic         rst;
    logic         bundle_valid;
    logic [127:0] bundle_ops;
    logic [5:0]   port_valid;
    logic [191:0] port_op;
    logic [11:0]  port_pos;
    logic         bundle_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    vliw_issue_dispatch dut (
        .clk          (clk),
        .rst          (rst),
        .bundle_valid (bundle_valid),
        .bundle_ops   (bundle_ops),
        .port_valid   (port_valid),
        .port_op      (port_op),
        .port_pos     (port_pos),
        .bundle_err   (bundle_err)
    );

    logic [31:0] exp_op  [6];
    logic [1:0]  exp_pos [6];
    logic        exp_vld [6];
    logic        exp_err;
    string       err_tag;

    task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] want);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, want);
        end
    endtask

    // Bench-side model of bundle length, class counting and port choice.
    task automatic model(input logic [127:0] ops);
        int  n, cnt [3], rank, c, p;
        bit  seen, rsv, ovf;
        n = 0; seen = 0; rsv = 0; ovf = 0;
        for (int k = 0; k < 3; k++) cnt[k] = 0;
        for (int p2 = 0; p2 < 6; p2++) begin
            exp_op[p2] = '0; exp_pos[p2] = '0; exp_vld[p2] = 1'b0;
        end
        for (int i = 0; i < 4; i++) begin
            if (!seen) begin
                n++;
                if (ops[32*i+31]) seen = 1;
            end
        end
        for (int i = 0; i < n; i++) begin
            c = int'(ops[32*i+29 +: 2]);
            if (c == 3) rsv = 1;
            else begin
                rank = cnt[c];
                cnt[c]++;
                if (rank < 2) begin
                    p = (c == 2) ? 4 + rank : rank * 2 + c;
                    exp_vld[p] = 1'b1;
                    exp_pos[p] = 2'(i);
                    exp_op[p]  = ops[32*i +: 32];
                end else ovf = 1;
            end
        end
        exp_err = !seen || rsv || ovf;
        err_tag = !seen ? "R8" : (rsv ? "R7" : (ovf ? "R6" : "R2"));
        if (exp_err)
            for (int p2 = 0; p2 < 6; p2++) begin
                exp_op[p2] = '0; exp_pos[p2] = '0; exp_vld[p2] = 1'b0;
            end
    endtask

    task automatic compare_ports(input string why);
        chk(bundle_err == exp_err, {why, " err ", err_tag}, 32'(bundle_err), 32'(exp_err));
        for (int p = 0; p < 6; p++) begin
            chk(port_valid[p] == exp_vld[p], {why, " R4 valid"}, 32'(port_valid[p]),
                32'(exp_vld[p]));
            chk(port_op[32*p +: 32] == exp_op[p], {why, " R5/R11 op"}, port_op[32*p +: 32],
                exp_op[p]);
            chk(port_pos[2*p +: 2] == exp_pos[p], {why, " R5/R11 pos"},
                32'(port_pos[2*p +: 2]), 32'(exp_pos[p]));
        end
    endtask

    function automatic logic [127:0] build(input int combo);
        logic [127:0] v;
        for (int i = 0; i < 4; i++) begin
            v[32*i+31]    = combo[8+i];
            v[32*i+29 +: 2] = 2'(combo >> (2*i));
            v[32*i +: 29] = 29'(32'h0A50_0000 + combo * 4 + i);
        end
        return v;
    endfunction

    initial begin
        rst = 1'b1;
        bundle_valid = 1'b1;
        bundle_ops = build(12'h1C4);
        repeat (3) @(negedge clk);
        // R1: reset state while held in reset
        chk(port_valid == '0 && bundle_err == 1'b0 && port_op == '0 && port_pos == '0,
            "R1 reset", 32'(port_valid), 32'h0);
        rst = 1'b0;
        bundle_valid = 1'b0;
        @(negedge clk);

        // R10: integer op at lane 0 with end bit; must not appear before the edge
        bundle_valid = 1'b1;
        bundle_ops = build(12'h100);
        #1;
        chk(port_valid == '0, "R10 before edge", 32'(port_valid), 32'h0);
        @(negedge clk);
        chk(port_valid == 6'b000001, "R10 after edge", 32'(port_valid), 32'h1);

        // R9: idle cycle with live-looking data on the bus
        bundle_valid = 1'b0;
        bundle_ops = build(12'h1E4);
        @(negedge clk);
        chk(port_valid == '0 && !bundle_err, "R9 idle ignored", 32'(port_valid), 32'h0);

        // R2/R3/R4/R5/R6/R7/R8/R11: full sweep of class codes and end-bit patterns
        for (int combo = 0; combo < 4096; combo++) begin
            bundle_valid = 1'b1;
            bundle_ops = build(combo);
            model(bundle_ops);
            @(negedge clk);
            compare_ports($sformatf("combo %0h", combo));
            if (combo % 512 == 0) begin
                bundle_valid = 1'b0;
                bundle_ops = ~bundle_ops;
                @(negedge clk);
                chk(port_valid == '0 && !bundle_err && port_op == '0,
                    "R9 idle after bundle", 32'(port_valid), 32'h0);
            end
        end

        // R1: reset asserted mid-stream clears registered outputs on the next edge
        bundle_valid = 1'b1;
        bundle_ops = build(12'h1A4);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(port_valid == '0 && port_op == '0, "R1 reset mid-run", 32'(port_valid), 32'h0);
        rst = 1'b0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule